// File: doc/BRIEF.md
# Radio Data Stream Group Synchroniser

This block watches a serial radio-data bit stream and finds where its 26-bit blocks and four-block groups begin. Each bit arrives on `bit_in` and is qualified by a one-cycle `bit_en` pulse; the first bit of a block is the most significant data bit. Before lock, the block slides a 26-bit window along the stream one bit at a time. At every bit it checks whether the window holds 16 data bits followed by a 10-bit checkword that matches one of the recognised offset patterns.

Lock is declared as soon as two offsets line up in the right group order, either in adjacent blocks or with one block between them. Once locked, the block counts bits itself. It raises a strobe at the end of every block, with the block's position in the group, and it watches the expected offset at each boundary. From the offsets it derives a group-variant flag and a qualifier that marks where downstream output may begin. A run of blocks with no expected offset drops the lock, raises an error pulse and starts the search again. Error correction and the serial output are handled elsewhere.

Top module: `rds_group_sync`

## Requirements
- R1: While `rst` is high at a rising edge, every output is driven to 0 on that edge: `locked`, `blk_stb`, `out_qual`, `sync_err`, `grp_b` and `blk_idx`.
- R2: A window is a hit only if its low 10 bits equal C(d) XOR k. Here d is the high 16 bits and C(d) is d·x^10 mod x^10+x^8+x^7+x^5+x^4+x^3+1. The value k is one of 0x0FC (position 0), 0x198 (position 1), 0x168 (position 2, variant A), 0x350 (position 2, variant B) or 0x1B4 (position 3). Any other k, including 0x000 and 0x2AA, never counts.
- R3: A window whose 16 data bits are all zero is never a hit, even when its checkword carries a valid offset.
- R4: While searching, a hit at position p completes lock in one of two cases: a hit at position p-1 (mod 4) came exactly 26 bits earlier, or a hit at position p-2 (mod 4) came exactly 52 bits earlier. The bit phase does not matter, and hits in the wrong order never lock. On the lock edge `locked` rises, `blk_stb` pulses and `blk_idx` equals p. All outputs change on the second rising edge after the edge that samples the final bit.
- R5: While locked, `blk_stb` pulses once every 26 bits, at the last bit of each block. At each pulse `blk_idx` advances by one, wrapping from 3 to 0.
- R6: If lock completed at position 0, `out_qual` rises with the next strobe (position 1). Otherwise it rises with the next strobe at position 0. It then stays high until lock is lost.
- R7: `grp_b` becomes 1 when a block at position 2 carries offset 0x350 and 0 when it carries 0x168. This applies on the lock edge as well. It does not change at any other time.
- R8: A boundary counts as a miss when the finished block does not carry the offset expected for its new position. When a sixth consecutive miss occurs, `locked` and `out_qual` fall, `sync_err` pulses for one cycle and no strobe is given. Any boundary that is not a miss resets the run of misses.
- R9: `locked` is high only between a lock edge and the following loss of lock. No strobe occurs while it is low.
- R10: After a loss of lock the search restarts, and a new pair of hits can lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle qualifier for a new stream bit |
| bit_in | input | 1 | Stream bit, sampled when `bit_en` is high |
| locked | output | 1 | High while group sync is held |
| blk_idx | output | 2 | Position of the block just finished (0..3) |
| grp_b | output | 1 | Group variant taken from the position-2 offset |
| blk_stb | output | 1 | One-cycle pulse at each block end while locked |
| out_qual | output | 1 | High from the first block that may be output |
| sync_err | output | 1 | One-cycle pulse when lock is lost |

## Verification
Every result is due on the second rising edge after the edge that samples a bit. One edge loads the window and the next one acts on it. The bench spaces bits two cycles apart and samples outputs at the falling edge that follows the acting edge. This way each strobe or error pulse is tied to exactly one bit. For every block the bench counts the strobes and records the bit position where each one appeared. It then compares the lock flag, position, qualifier and error flag against values worked out from the offsets it sent.

// File: rtl/rds_sync_pkg.sv
package rds_sync_pkg;

    localparam int BLK_W   = 26;
    localparam int DAT_W   = 16;
    localparam int CHK_W   = BLK_W - DAT_W;

    // generator x^10+x^8+x^7+x^5+x^4+x^3+1 without its top term
    localparam logic [CHK_W-1:0] GEN_LOW = 10'h1B9;

    localparam logic [CHK_W-1:0] OFS_P0  = 10'h0FC;
    localparam logic [CHK_W-1:0] OFS_P1  = 10'h198;
    localparam logic [CHK_W-1:0] OFS_P2A = 10'h168;
    localparam logic [CHK_W-1:0] OFS_P2B = 10'h350;
    localparam logic [CHK_W-1:0] OFS_P3  = 10'h1B4;

    typedef enum logic {ST_SEARCH, ST_TRACK} sync_st_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] pos;
        logic       alt;   // position 2 carried the second variant
    } hit_t;

    // data * x^10 mod generator, serial division MSB first
    function automatic logic [CHK_W-1:0] chk_of(input logic [DAT_W-1:0] d);
        logic [CHK_W-1:0] r;
        logic             fb;
        r = '0;
        for (int i = DAT_W - 1; i >= 0; i--) begin
            fb = r[CHK_W-1] ^ d[i];
            r  = {r[CHK_W-2:0], 1'b0};
            if (fb) r = r ^ GEN_LOW;
        end
        return r;
    endfunction

endpackage

// File: rtl/rds_shift_window.sv
module rds_shift_window
    import rds_sync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [BLK_W-1:0] win,
    output logic             win_new
);
    always_ff @(posedge clk) begin
        if (rst) begin
            win     <= '0;
            win_new <= 1'b0;
        end else begin
            win_new <= bit_en;
            if (bit_en) win <= {win[BLK_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/rds_offset_match.sv
module rds_offset_match
    import rds_sync_pkg::*;
(
    input  logic [BLK_W-1:0] win,
    output hit_t             hit
);
    logic [DAT_W-1:0] data;
    logic [CHK_W-1:0] ofs;

    always_comb begin
        data = win[BLK_W-1:CHK_W];
        ofs  = win[CHK_W-1:0] ^ chk_of(data);
        hit  = '0;
        if (data != '0) begin
            unique case (ofs)
                OFS_P0:  begin hit.hit = 1'b1; hit.pos = 2'd0; end
                OFS_P1:  begin hit.hit = 1'b1; hit.pos = 2'd1; end
                OFS_P2A: begin hit.hit = 1'b1; hit.pos = 2'd2; end
                OFS_P2B: begin hit.hit = 1'b1; hit.pos = 2'd2; hit.alt = 1'b1; end
                OFS_P3:  begin hit.hit = 1'b1; hit.pos = 2'd3; end
                default: hit = '0;
            endcase
        end
    end
endmodule

// File: rtl/rds_sync_fsm.sv
module rds_sync_fsm
    import rds_sync_pkg::*;
#(
    parameter int MISS_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       win_new,
    input  hit_t       hit,
    output logic       locked,
    output logic [1:0] blk_idx,
    output logic       grp_b,
    output logic       blk_stb,
    output logic       out_qual,
    output logic       sync_err
);
    localparam int HIST_D = 2 * BLK_W;
    localparam int CNT_W  = $clog2(BLK_W);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    sync_st_e          st;
    hit_t              hist [HIST_D];
    logic [CNT_W-1:0]  bit_cnt;
    logic [MISS_W-1:0] miss_cnt;
    logic              pend_next;

    logic       pair_adj, pair_gap, lock_now, at_end, good;
    logic [1:0] nidx;

    always_comb begin
        pair_adj = hist[BLK_W-1].hit  && (hist[BLK_W-1].pos  == hit.pos - 2'd1);
        pair_gap = hist[HIST_D-1].hit && (hist[HIST_D-1].pos == hit.pos - 2'd2);
        lock_now = (st == ST_SEARCH) && hit.hit && (pair_adj || pair_gap);
        at_end   = (bit_cnt == CNT_W'(BLK_W - 1));
        nidx     = blk_idx + 2'd1;
        good     = hit.hit && (hit.pos == nidx);
    end

    // hit history, only filled while searching
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST_D; i++) hist[i] <= '0;
        end else if (win_new) begin
            hist[0] <= (st == ST_SEARCH) ? hit : '0;
            for (int i = 1; i < HIST_D; i++) hist[i] <= hist[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_SEARCH;
            bit_cnt   <= '0;
            miss_cnt  <= '0;
            pend_next <= 1'b0;
            blk_idx   <= 2'd0;
            grp_b     <= 1'b0;
            blk_stb   <= 1'b0;
            out_qual  <= 1'b0;
            sync_err  <= 1'b0;
        end else begin
            blk_stb  <= 1'b0;
            sync_err <= 1'b0;
            if (win_new) begin
                if (st == ST_SEARCH) begin
                    if (lock_now) begin
                        st        <= ST_TRACK;
                        blk_idx   <= hit.pos;
                        blk_stb   <= 1'b1;
                        bit_cnt   <= '0;
                        miss_cnt  <= '0;
                        out_qual  <= 1'b0;
                        pend_next <= (hit.pos == 2'd0);
                        if (hit.pos == 2'd2) grp_b <= hit.alt;
                    end
                end else if (!at_end) begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end else if (!good && miss_cnt == MISS_W'(MISS_LIMIT)) begin
                    st        <= ST_SEARCH;
                    sync_err  <= 1'b1;
                    out_qual  <= 1'b0;
                    pend_next <= 1'b0;
                    bit_cnt   <= '0;
                    miss_cnt  <= '0;
                end else begin
                    bit_cnt   <= '0;
                    blk_idx   <= nidx;
                    blk_stb   <= 1'b1;
                    miss_cnt  <= good ? '0 : miss_cnt + MISS_W'(1);
                    out_qual  <= out_qual | pend_next | (nidx == 2'd0);
                    pend_next <= 1'b0;
                    if (good && nidx == 2'd2) grp_b <= hit.alt;
                end
            end
        end
    end

    assign locked = (st == ST_TRACK);
endmodule

// File: rtl/rds_group_sync.sv
module rds_group_sync
    import rds_sync_pkg::*;
#(
    parameter int MISS_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic       locked,
    output logic [1:0] blk_idx,
    output logic       grp_b,
    output logic       blk_stb,
    output logic       out_qual,
    output logic       sync_err
);
    logic [BLK_W-1:0] win;
    logic             win_new;
    hit_t             hit;

    rds_shift_window u_win (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .win     (win),
        .win_new (win_new)
    );

    rds_offset_match u_match (
        .win (win),
        .hit (hit)
    );

    rds_sync_fsm #(.MISS_LIMIT(MISS_LIMIT)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .win_new  (win_new),
        .hit      (hit),
        .locked   (locked),
        .blk_idx  (blk_idx),
        .grp_b    (grp_b),
        .blk_stb  (blk_stb),
        .out_qual (out_qual),
        .sync_err (sync_err)
    );
endmodule

// File: rtl/rds_group_sync_chk.sv
module rds_group_sync_chk (
    input logic       clk,
    input logic       rst,
    input logic       locked,
    input logic [1:0] blk_idx,
    input logic       grp_b,
    input logic       blk_stb,
    input logic       out_qual,
    input logic       sync_err
);
    logic       have_prev;
    logic [1:0] last_idx;

    always_ff @(posedge clk) begin
        if (rst || !locked) begin
            have_prev <= 1'b0;
            last_idx  <= 2'd0;
        end else if (blk_stb) begin
            have_prev <= 1'b1;
            last_idx  <= blk_idx;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!locked && !blk_stb && !out_qual && !sync_err && !grp_b && blk_idx == 2'd0));

    a_r9_stb_needs_lock: assert property (@(posedge clk) disable iff (rst)
        blk_stb |-> locked);

    a_r5_idx_step: assert property (@(posedge clk) disable iff (rst)
        (blk_stb && have_prev) |-> (blk_idx == last_idx + 2'd1));

    a_r6_qual_needs_lock: assert property (@(posedge clk) disable iff (rst)
        out_qual |-> locked);

    a_r8_err_on_drop: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> (!locked && $past(locked) && !blk_stb));

    a_r7_grp_only_at_stb: assert property (@(posedge clk) disable iff (rst)
        !$stable(grp_b) |-> blk_stb);
endmodule

bind rds_group_sync rds_group_sync_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .locked   (locked),
    .blk_idx  (blk_idx),
    .grp_b    (grp_b),
    .blk_stb  (blk_stb),
    .out_qual (out_qual),
    .sync_err (sync_err)
);

// File: tb/tb_rds_group_sync.sv
`timescale 1ns/1ps
module tb_rds_group_sync;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       locked, grp_b, blk_stb, out_qual, sync_err;
    logic [1:0] blk_idx;

    int n_run = 0;
    int n_bad = 0;
    bit finished = 0;

    int stb_cnt, stb_pos, err_seen;
    logic [1:0] stb_val;

    localparam logic [9:0] K0 = 10'h0FC, K1 = 10'h198, K2 = 10'h168,
                           K2B = 10'h350, K3 = 10'h1B4, KJ = 10'h2AA;

    always #2.5 clk = ~clk;

    rds_group_sync dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .locked(locked), .blk_idx(blk_idx), .grp_b(grp_b),
        .blk_stb(blk_stb), .out_qual(out_qual), .sync_err(sync_err)
    );

    function automatic logic [9:0] tb_chk(input logic [15:0] d);
        logic [25:0] v;
        v = {d, 10'b0};
        for (int i = 25; i >= 10; i--)
            if (v[i]) v = v ^ (26'h5B9 << (i - 10));
        return v[9:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int pos);
        bit_in = b;
        bit_en = 1'b1;
        @(posedge clk); @(negedge clk);
        bit_en = 1'b0;
        @(posedge clk); @(negedge clk);
        if (blk_stb) begin stb_cnt++; stb_pos = pos; stb_val = blk_idx; end
        if (sync_err) err_seen++;
    endtask

    task automatic send_block(input logic [15:0] d, input logic [9:0] k);
        logic [25:0] blk;
        blk = {d, tb_chk(d) ^ k};
        stb_cnt = 0; stb_pos = -1; err_seen = 0; stb_val = 2'd0;
        for (int i = 25; i >= 0; i--) send_bit(blk[i], 25 - i);
    endtask

    task automatic expect_blk(input string req, input bit lk, input bit stb,
                              input int idx, input bit oq, input bit er);
        check(locked == lk, {req, " locked"}, locked, lk);
        if (stb) begin
            check(stb_cnt == 1 && stb_pos == 25, {req, " strobe at block end"}, stb_pos, 25);
            check(int'(stb_val) == idx, {req, " block index"}, stb_val, idx);
        end else begin
            check(stb_cnt == 0, {req, " no strobe"}, stb_cnt, 0);
        end
        check(out_qual == oq, {req, " out_qual"}, out_qual, oq);
        check((err_seen != 0) == er, {req, " sync_err"}, err_seen, er);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!locked && !blk_stb && !out_qual && !sync_err && !grp_b && blk_idx == 0,
              "R1 reset state", {locked, blk_stb, out_qual, sync_err, grp_b, blk_idx}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!locked, "R9 idle after reset", locked, 0);
    endtask

    // lock on position 1 after a misaligned start
    task automatic t_lock_adjacent();
        do_reset();
        for (int i = 0; i < 7; i++) send_bit(i[0], i);
        send_block(16'h3C5A, KJ);  expect_blk("R2 junk",  0, 0, 0, 0, 0);
        send_block(16'h1234, K0);  expect_blk("R4 first", 0, 0, 0, 0, 0);
        send_block(16'hBEEF, K1);  expect_blk("R4 lock p1", 1, 1, 1, 0, 0);
        send_block(16'h0F0F, K2);  expect_blk("R5 p2", 1, 1, 2, 0, 0);
        check(grp_b == 0, "R7 variant A", grp_b, 0);
        send_block(16'h7711, K3);  expect_blk("R6 wait p3", 1, 1, 3, 0, 0);
        send_block(16'h4242, K0);  expect_blk("R6 start p0", 1, 1, 0, 1, 0);
        send_block(16'h9999, K1);  expect_blk("R5 wrap p1", 1, 1, 1, 1, 0);
    endtask

    task automatic t_lock_on_first();
        do_reset();
        send_block(16'hA5A5, K3);  expect_blk("R4 p3", 0, 0, 0, 0, 0);
        send_block(16'h5151, K0);  expect_blk("R4 lock p0", 1, 1, 0, 0, 0);
        send_block(16'h6161, K1);  expect_blk("R6 start next", 1, 1, 1, 1, 0);
    endtask

    task automatic t_gap_and_variant();
        do_reset();
        send_block(16'h1357, K0);  expect_blk("R4 gap first", 0, 0, 0, 0, 0);
        send_block(16'h2468, KJ);  expect_blk("R4 gap junk", 0, 0, 0, 0, 0);
        send_block(16'hCAFE, K2B); expect_blk("R4 gap lock", 1, 1, 2, 0, 0);
        check(grp_b == 1, "R7 variant B on lock", grp_b, 1);
        send_block(16'h0101, K3);  expect_blk("R6 p3", 1, 1, 3, 0, 0);
        send_block(16'h0202, K0);  expect_blk("R6 p0", 1, 1, 0, 1, 0);
        check(grp_b == 1, "R7 held", grp_b, 1);
        send_block(16'h0303, K1);  expect_blk("R5 p1", 1, 1, 1, 1, 0);
        send_block(16'h0404, K2);  expect_blk("R5 p2", 1, 1, 2, 1, 0);
        check(grp_b == 0, "R7 back to variant A", grp_b, 0);
    endtask

    // continues from the locked state at position 2
    task automatic t_loss_and_relock();
        int e;
        e = 2;
        for (int i = 0; i < 5; i++) begin
            e = (e + 1) % 4;
            send_block(16'h1111 * (i + 1), KJ);
            expect_blk("R8 miss held", 1, 1, e, 1, 0);
        end
        send_block(16'h7E7E, K0);  expect_blk("R8 good resets", 1, 1, 0, 1, 0);
        e = 0;
        for (int i = 0; i < 5; i++) begin
            e = (e + 1) % 4;
            send_block(16'h2222 * (i + 1), KJ);
            expect_blk("R8 miss again", 1, 1, e, 1, 0);
        end
        send_block(16'hDEAD, KJ);  expect_blk("R8 sixth miss drops", 0, 0, 0, 0, 1);
        send_block(16'h4321, K1);  expect_blk("R9 searching", 0, 0, 0, 0, 0);
        send_block(16'h8765, K2);  expect_blk("R10 relock", 1, 1, 2, 0, 0);
    endtask

    task automatic t_zero_data();
        do_reset();
        send_block(16'h0000, K0);  expect_blk("R3 zero data", 0, 0, 0, 0, 0);
        send_block(16'h5A5A, K1);  expect_blk("R3 no pair", 0, 0, 0, 0, 0);
        send_block(16'h6B6B, K2);  expect_blk("R3 later lock", 1, 1, 2, 0, 0);
    endtask

    task automatic t_unlisted_and_order();
        do_reset();
        send_block(16'h1A2B, 10'h000); expect_blk("R2 unlisted", 0, 0, 0, 0, 0);
        send_block(16'h3C4D, K1);      expect_blk("R2 no pair", 0, 0, 0, 0, 0);
        send_block(16'h5E6F, K0);      expect_blk("R4 wrong order", 0, 0, 0, 0, 0);
        send_block(16'h7081, K1);      expect_blk("R4 right order", 1, 1, 1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_lock_adjacent();
        t_lock_on_first();
        t_gap_and_variant();
        t_loss_and_relock();
        t_zero_data();
        t_unlisted_and_order();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule